// File: doc/BRIEF.md
# Byte-Wide Memory DMA Engine

This engine moves a block of words between a byte-wide external memory and the on-chip program or data memory. Software sets up the transfer through a small register port. The setup holds the internal start address, the external byte address and its page, a control word, a wait-state count, and finally the word count. Writing a nonzero word count starts the transfer. On a load, the engine reads bytes one at a time, most significant byte first, and builds a 24-, 16- or 8-bit word. It then writes that word to internal memory in a single cycle. On a store, it reads one internal word in a single cycle and writes it out as bytes.

The engine gives way to processor accesses on the external bus. Each byte access is stretched by the programmed wait states. When the last word is done, the engine raises a one-cycle interrupt. In halt mode it also holds the processor for the whole transfer and sends it a restart pulse at the end.

The controller is a four-state machine:
- `ST_IDLE`: waits for a start.
- `ST_BYTE`: performs byte accesses, with waits.
- `ST_WORD`: performs the single internal-memory cycle.
- `ST_DONE`: lasts one cycle and signals completion.

Its transitions are:
- IDLE→BYTE on a start with load direction.
- IDLE→WORD on a start with store direction.
- BYTE→WORD after the last byte of a word on a load, or on a store that has words left.
- BYTE→DONE after the last byte of the final word on a store.
- WORD→BYTE on a store, or on a load that has words left.
- WORD→DONE on the final word of a load.
- DONE→IDLE always.

Top module: `bytedma_ctrl`

## Requirements
- R1: A register write of a nonzero value to the count register (select 5) while idle starts a transfer: busy_o is 1 and wcount_o shows the value at the next falling clock edge. Writing zero starts nothing.
- R2: wcount_o drops by exactly one per word moved. It is 0 when the transfer ends. No word past the programmed count is touched.
- R3: Format code 0 (control bits [1:0] = 00) moves 24-bit program-memory words (im_pm=1) as three bytes, most significant first.
- R4: Format code 1 moves 16-bit data-memory words as two bytes, high byte first. Bits 23:16 are written as zero on a load.
- R5: Format code 2 places a single byte in bits 15:8 of a data-memory word, and code 3 places it in bits 7:0. All other bits are zero on a load. On a store, the byte is taken from those same bits.
- R6: The 22-bit external address {page, byte address} steps by one per byte access. It carries from the 14-bit byte address into the 8-bit page.
- R7: The internal address steps by one per word, starting from the programmed value.
- R8: Control bit 2 chooses the direction: 0 loads from byte memory into internal memory, and 1 stores internal memory to byte memory.
- R9: Every byte access keeps bm_req high at one address for exactly wait+1 cycles, where wait is the value at select 4.
- R10: No byte access begins in a cycle in which core_ext_req is high.
- R11: At the end, irq pulses for exactly one cycle. With control bit 3 set, core_hold is high for the whole busy period and core_rst pulses together with irq. With bit 3 clear, neither is asserted. Control bits [7:4] appear on ovl_sel.
- R12: Register writes are ignored while a transfer is busy. This includes writes to the count and control registers.
- R13: Each word makes exactly one im_req, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 int addr, 1 byte addr, 2 page, 3 control, 4 wait, 5 count |
| cfg_wdata | input | 16 | Register write data |
| core_ext_req | input | 1 | Processor wants the external bus (has priority) |
| bm_req | output | 1 | Byte memory access active |
| bm_we | output | 1 | Byte memory write |
| bm_addr | output | 22 | Byte memory address {page, byte address} |
| bm_wdata | output | 8 | Byte write data |
| bm_rdata | input | 8 | Byte read data, sampled in the last access cycle |
| im_req | output | 1 | Internal memory access, single cycle |
| im_we | output | 1 | Internal memory write |
| im_pm | output | 1 | 1 = program memory, 0 = data memory |
| im_addr | output | 14 | Internal memory address |
| im_wdata | output | 24 | Internal write data |
| im_rdata | input | 24 | Internal read data, same cycle as im_req |
| irq | output | 1 | Completion pulse |
| core_hold | output | 1 | Holds the processor (halt mode) |
| core_rst | output | 1 | Processor restart pulse (halt mode) |
| busy_o | output | 1 | Transfer in progress |
| wcount_o | output | 14 | Live remaining word count |
| ovl_sel | output | 4 | Overlay bank field, passed through |

## Verification
The hardest case to reach is a carry from the byte address into the page that falls in the middle of a multi-byte word. This case also requires the processor to be claiming the bus at that moment. A directed run therefore starts a 24-bit load two bytes below the top of a page, so the carry lands between the second and third byte of the first word. Random runs then drive core_ext_req high on about a third of cycles, with random wait states and formats. In these runs, the yield check sees new accesses starting right next to processor bus claims.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

    localparam int OVL_W = 4;

    typedef enum logic [1:0] {
        FMT_PM24  = 2'b00,
        FMT_DM16  = 2'b01,
        FMT_DM8HI = 2'b10,
        FMT_DM8LO = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BYTE,
        ST_WORD,
        ST_DONE
    } state_e;

    typedef enum logic [2:0] {
        SEL_IADDR = 3'd0,
        SEL_EADDR = 3'd1,
        SEL_PAGE  = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_WAIT  = 3'd4,
        SEL_COUNT = 3'd5
    } sel_e;

    typedef struct packed {
        logic [OVL_W-1:0] ovl;
        logic             halt;
        logic             dir;
        fmt_e             fmt;
    } ctrl_t;

    function automatic logic [1:0] last_byte_idx(fmt_e f);
        unique case (f)
            FMT_PM24: return 2'd2;
            FMT_DM16: return 2'd1;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/bdma_regs.sv
module bdma_regs
    import bdma_pkg::*;
#(
    parameter int IADDR_W = 14,
    parameter int EADDR_W = 14,
    parameter int PAGE_W  = 8,
    parameter int CNT_W   = 14,
    parameter int WAIT_W  = 3,
    parameter int CFG_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [2:0]                 cfg_sel,
    input  logic [CFG_W-1:0]           cfg_wdata,
    input  logic                       busy,
    input  logic                       inc_int,
    input  logic                       inc_ext,
    input  logic                       dec_cnt,
    output logic [IADDR_W-1:0]         int_addr,
    output logic [EADDR_W+PAGE_W-1:0]  ext_addr,
    output ctrl_t                      ctrl,
    output logic [WAIT_W-1:0]          wait_q,
    output logic [CNT_W-1:0]           count,
    output logic                       start
);
    localparam int BM_AW  = EADDR_W + PAGE_W;
    localparam int CTRL_W = $bits(ctrl_t);

    logic wr_ok;
    assign wr_ok = cfg_we && !busy;
    assign start = wr_ok && (cfg_sel == SEL_COUNT) && (cfg_wdata[CNT_W-1:0] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_addr <= '0;
            ext_addr <= '0;
            ctrl     <= '0;
            wait_q   <= '0;
            count    <= '0;
        end else if (wr_ok) begin
            unique case (cfg_sel)
                SEL_IADDR: int_addr <= cfg_wdata[IADDR_W-1:0];
                SEL_EADDR: ext_addr[EADDR_W-1:0] <= cfg_wdata[EADDR_W-1:0];
                SEL_PAGE:  ext_addr[BM_AW-1:EADDR_W] <= cfg_wdata[PAGE_W-1:0];
                SEL_CTRL:  ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                SEL_WAIT:  wait_q <= cfg_wdata[WAIT_W-1:0];
                SEL_COUNT: count <= cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end else begin
            if (inc_int) int_addr <= int_addr + 1'b1;
            if (inc_ext) ext_addr <= ext_addr + 1'b1;
            if (dec_cnt) count <= count - 1'b1;
        end
    end

    // R2: the engine never counts below zero
    p_cnt_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_cnt |-> (count != '0));

    // R12: a busy engine keeps its programming
    p_ctrl_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctrl));

endmodule

// File: rtl/bdma_pack.sv
module bdma_pack
    import bdma_pkg::*;
(
    input  fmt_e        fmt,
    input  logic [23:0] acc,
    input  logic [23:0] word_q,
    input  logic [1:0]  byte_idx,
    output logic [23:0] im_wdata,
    output logic [7:0]  bm_wdata
);
    always_comb begin
        unique case (fmt)
            FMT_PM24:  im_wdata = acc;
            FMT_DM16:  im_wdata = {8'h00, acc[15:0]};
            FMT_DM8HI: im_wdata = {8'h00, acc[7:0], 8'h00};
            FMT_DM8LO: im_wdata = {16'h0000, acc[7:0]};
        endcase
    end

    always_comb begin
        bm_wdata = 8'h00;
        unique case (fmt)
            FMT_PM24: begin
                unique case (byte_idx)
                    2'd0:    bm_wdata = word_q[23:16];
                    2'd1:    bm_wdata = word_q[15:8];
                    default: bm_wdata = word_q[7:0];
                endcase
            end
            FMT_DM16:  bm_wdata = (byte_idx == 2'd0) ? word_q[15:8] : word_q[7:0];
            FMT_DM8HI: bm_wdata = word_q[15:8];
            FMT_DM8LO: bm_wdata = word_q[7:0];
        endcase
    end
endmodule

// File: rtl/bytedma_ctrl.sv
module bytedma_ctrl
    import bdma_pkg::*;
#(
    parameter int IADDR_W = 14,
    parameter int EADDR_W = 14,
    parameter int PAGE_W  = 8,
    parameter int CNT_W   = 14,
    parameter int WAIT_W  = 3,
    parameter int CFG_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [2:0]                cfg_sel,
    input  logic [CFG_W-1:0]          cfg_wdata,
    input  logic                      core_ext_req,
    output logic                      bm_req,
    output logic                      bm_we,
    output logic [EADDR_W+PAGE_W-1:0] bm_addr,
    output logic [7:0]                bm_wdata,
    input  logic [7:0]                bm_rdata,
    output logic                      im_req,
    output logic                      im_we,
    output logic                      im_pm,
    output logic [IADDR_W-1:0]        im_addr,
    output logic [23:0]               im_wdata,
    input  logic [23:0]               im_rdata,
    output logic                      irq,
    output logic                      core_hold,
    output logic                      core_rst,
    output logic                      busy_o,
    output logic [CNT_W-1:0]          wcount_o,
    output logic [OVL_W-1:0]          ovl_sel
);
    localparam int BM_AW = EADDR_W + PAGE_W;

    state_e               state, nxt;
    ctrl_t                ctrl;
    logic [IADDR_W-1:0]   int_addr;
    logic [BM_AW-1:0]     ext_addr;
    logic [WAIT_W-1:0]    wait_q, wcnt;
    logic [CNT_W-1:0]     count;
    logic                 start, acc_act;
    logic [23:0]          acc, word_q;
    logic [1:0]           byte_idx, last_idx;
    logic                 bm_go, byte_end, word_end, is_store, final_word;
    logic                 inc_int, inc_ext, dec_cnt;

    assign is_store   = ctrl.dir;
    assign last_idx   = last_byte_idx(ctrl.fmt);
    assign final_word = (count == {{(CNT_W-1){1'b0}}, 1'b1});
    assign bm_go      = (state == ST_BYTE) && (acc_act || !core_ext_req);
    assign byte_end   = bm_go && (wcnt == wait_q);
    assign word_end   = byte_end && (byte_idx == last_idx);
    assign inc_int    = (state == ST_WORD);
    assign inc_ext    = byte_end;
    assign dec_cnt    = is_store ? word_end : (state == ST_WORD);

    bdma_regs #(
        .IADDR_W(IADDR_W), .EADDR_W(EADDR_W), .PAGE_W(PAGE_W),
        .CNT_W(CNT_W), .WAIT_W(WAIT_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy_o), .inc_int(inc_int),
        .inc_ext(inc_ext), .dec_cnt(dec_cnt), .int_addr(int_addr),
        .ext_addr(ext_addr), .ctrl(ctrl), .wait_q(wait_q), .count(count),
        .start(start)
    );

    bdma_pack u_pack (
        .fmt(ctrl.fmt), .acc(acc), .word_q(word_q), .byte_idx(byte_idx),
        .im_wdata(im_wdata), .bm_wdata(bm_wdata)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ctrl.dir ? ST_WORD : ST_BYTE;
            ST_BYTE: if (word_end) nxt = (is_store && final_word) ? ST_DONE : ST_WORD;
            ST_WORD: nxt = (!is_store && final_word) ? ST_DONE : ST_BYTE;
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_act  <= 1'b0;
            wcnt     <= '0;
            byte_idx <= '0;
            acc      <= '0;
            word_q   <= '0;
        end else begin
            if (start) begin
                acc_act  <= 1'b0;
                wcnt     <= '0;
                byte_idx <= '0;
            end else if (bm_go) begin
                if (byte_end) begin
                    acc_act  <= 1'b0;
                    wcnt     <= '0;
                    acc      <= {acc[15:0], bm_rdata};
                    byte_idx <= (byte_idx == last_idx) ? 2'd0 : byte_idx + 2'd1;
                end else begin
                    acc_act <= 1'b1;
                    wcnt    <= wcnt + 1'b1;
                end
            end
            if (state == ST_WORD && is_store) word_q <= im_rdata;
        end
    end

    always_comb begin
        bm_req    = bm_go;
        bm_we     = is_store;
        bm_addr   = ext_addr;
        im_req    = (state == ST_WORD);
        im_we     = !is_store;
        im_pm     = (ctrl.fmt == FMT_PM24);
        im_addr   = int_addr;
        busy_o    = (state != ST_IDLE);
        irq       = (state == ST_DONE);
        core_hold = (state != ST_IDLE) && ctrl.halt;
        core_rst  = (state == ST_DONE) && ctrl.halt;
        wcount_o  = count;
        ovl_sel   = ctrl.ovl;
    end

    // R10: a byte access never opens while the processor holds the bus
    p_core_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req && core_ext_req) |-> ($past(bm_req) && $stable(bm_addr)));

    // R13: internal memory sees a single-cycle request per word
    p_im_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        im_req |=> !im_req);

    // R2: completion only with the count exhausted
    p_irq_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (wcount_o == '0));

    // R11: restart pulse only in halt mode, together with the interrupt
    p_rst_with_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (irq && core_hold));

    // R6: external address moves by one after each finished byte
    p_ext_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && byte_end) |=> (bm_addr == $past(bm_addr) + 1'b1));

endmodule

// File: tb/test_bytedma_ctrl.sv
module test_bytedma_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        core_ext_req = 1'b0;
    logic        bm_req, bm_we, im_req, im_we, im_pm;
    logic        irq, core_hold, core_rst, busy_o;
    logic [21:0] bm_addr;
    logic [7:0]  bm_wdata, bm_rdata;
    logic [13:0] im_addr, wcount_o;
    logic [23:0] im_wdata, im_rdata;
    logic [3:0]  ovl_sel;

    int checks = 0, fails = 0, cycles = 0;
    int irq_cnt = 0, rst_cnt = 0;
    bit cur_halt = 0, rnd_core = 0;
    int cur_wait = 0, run_len = 0;
    logic        prev_req = 0;
    logic [21:0] prev_addr = '0;
    logic [13:0] prev_cnt = '0;
    logic        prev_busy = 0;

    logic [23:0] pmem [256];
    logic [23:0] dmem [256];
    logic [7:0]  bmem [int];

    always #5 clk = ~clk;

    bytedma_ctrl i_bytedma_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .core_ext_req(core_ext_req),
        .bm_req(bm_req), .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
        .bm_rdata(bm_rdata), .im_req(im_req), .im_we(im_we), .im_pm(im_pm),
        .im_addr(im_addr), .im_wdata(im_wdata), .im_rdata(im_rdata),
        .irq(irq), .core_hold(core_hold), .core_rst(core_rst), .busy_o(busy_o),
        .wcount_o(wcount_o), .ovl_sel(ovl_sel)
    );

    function automatic logic [7:0] bm_rd(int a);
        return bmem.exists(a) ? bmem[a] : 8'h00;
    endfunction

    assign bm_rdata = bm_rd(int'(bm_addr));
    assign im_rdata = im_pm ? pmem[im_addr[7:0]] : dmem[im_addr[7:0]];

    always @(posedge clk) begin
        if (bm_req && bm_we) bmem[int'(bm_addr)] = bm_wdata;
        if (im_req && im_we) begin
            if (im_pm) pmem[im_addr[7:0]] = im_wdata;
            else       dmem[im_addr[7:0]] = im_wdata;
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // processor bus claims
    always @(posedge clk) begin
        #1;
        core_ext_req <= rnd_core ? ($urandom % 3 == 0) : 1'b0;
    end

    // port monitors
    always @(negedge clk) begin
        if (rst_n) begin
            logic new_acc;
            new_acc = bm_req && (!prev_req || bm_addr != prev_addr);
            if (new_acc && core_ext_req) chk(0, "R10 access began under core claim", 1, 0);
            if (prev_req && (!bm_req || bm_addr != prev_addr))
                chk(run_len == cur_wait + 1, "R9 access length", run_len, cur_wait + 1);
            run_len = bm_req ? (new_acc ? 1 : run_len + 1) : 0;
            if (prev_busy && busy_o && wcount_o != prev_cnt && wcount_o != prev_cnt - 14'd1)
                chk(0, "R2 count step", wcount_o, prev_cnt - 14'd1);
            if (core_hold !== (busy_o && cur_halt)) chk(0, "R11 hold", core_hold, busy_o && cur_halt);
            if (core_rst && !irq) chk(0, "R11 restart without irq", core_rst, 0);
            if (irq) irq_cnt++;
            if (core_rst) rst_cnt++;
            prev_req = bm_req; prev_addr = bm_addr;
            prev_cnt = wcount_o; prev_busy = busy_o;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(logic [2:0] sel, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int nbytes(logic [1:0] f);
        return (f == 2'b00) ? 3 : (f == 2'b01) ? 2 : 1;
    endfunction

    function automatic logic [23:0] exp_word(logic [1:0] f, int base, int k);
        int a;
        logic [7:0] b0, b1, b2;
        a  = base + k * nbytes(f);
        b0 = bm_rd((a) & 32'h3FFFFF);
        b1 = bm_rd((a + 1) & 32'h3FFFFF);
        b2 = bm_rd((a + 2) & 32'h3FFFFF);
        case (f)
            2'b00:   return {b0, b1, b2};
            2'b01:   return {8'h00, b0, b1};
            2'b10:   return {8'h00, b0, 8'h00};
            default: return {16'h0000, b0};
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(logic [1:0] f, logic [23:0] w, int j);
        case (f)
            2'b00:   return (j == 0) ? w[23:16] : (j == 1) ? w[15:8] : w[7:0];
            2'b01:   return (j == 0) ? w[15:8] : w[7:0];
            2'b10:   return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

    task automatic run_xfer(bit dir, logic [1:0] f, bit halt, int wt, int ia, int ea,
                            int pg, int n, bit poke, string tag);
        int base, t, nb;
        logic [3:0] ovl;
        logic [23:0] guard, src;
        base = (pg << 14) | ea;
        nb   = nbytes(f);
        ovl  = 4'($urandom);
        for (int j = 0; j < n * nb + 3; j++)
            if (!dir) bmem[(base + j) & 32'h3FFFFF] = 8'($urandom);
        for (int k = 0; k < n + 1; k++) begin
            pmem[(ia + k) & 255] = 24'($urandom);
            dmem[(ia + k) & 255] = 24'($urandom);
        end
        guard = (f == 2'b00) ? pmem[(ia + n) & 255] : dmem[(ia + n) & 255];
        wr(3'd0, 16'(ia)); wr(3'd1, 16'(ea)); wr(3'd2, 16'(pg));
        wr(3'd3, {8'h00, ovl, halt, dir, f}); wr(3'd4, 16'(wt));
        cur_halt = halt; cur_wait = wt; irq_cnt = 0; rst_cnt = 0;
        wr(3'd5, 16'(n));
        chk(busy_o == 1'b1, {"R1 start busy ", tag}, busy_o, 1);
        chk(wcount_o == 14'(n), {"R1 R2 count loaded ", tag}, wcount_o, n);
        chk(ovl_sel == ovl, {"R11 overlay pass ", tag}, ovl_sel, ovl);
        if (poke) begin
            wr(3'd5, 16'd9);
            wr(3'd3, {8'h00, ovl, halt, dir, 2'b00});
            wr(3'd0, 16'h00F0);
        end
        t = 0;
        while (busy_o && t < 20000) begin @(negedge clk); t++; end
        chk(!busy_o, {"R1 finished ", tag}, busy_o, 0);
        chk(wcount_o == 0, {"R2 count zero ", tag}, wcount_o, 0);
        chk(irq_cnt == 1, {"R11 one irq ", tag}, irq_cnt, 1);
        chk(rst_cnt == int'(halt), {"R11 restart pulses ", tag}, rst_cnt, halt);
        for (int k = 0; k < n; k++) begin
            if (!dir) begin
                logic [23:0] got;
                got = (f == 2'b00) ? pmem[(ia + k) & 255] : dmem[(ia + k) & 255];
                chk(got == exp_word(f, base, k), {"R3 R4 R5 R6 R7 R8 load word ", tag},
                    got, exp_word(f, base, k));
            end else begin
                src = (f == 2'b00) ? pmem[(ia + k) & 255] : dmem[(ia + k) & 255];
                for (int j = 0; j < nb; j++) begin
                    int a;
                    a = (base + k * nb + j) & 32'h3FFFFF;
                    chk(bm_rd(a) == exp_byte(f, src, j), {"R3 R4 R5 R6 R7 R8 store byte ", tag},
                        bm_rd(a), exp_byte(f, src, j));
                end
            end
        end
        if (!dir) begin
            logic [23:0] after;
            after = (f == 2'b00) ? pmem[(ia + n) & 255] : dmem[(ia + n) & 255];
            chk(after == guard, {"R2 R12 no extra word ", tag}, after, guard);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && bm_req == 0 && im_req == 0 && irq == 0, "R1 reset idle", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wcount_o == 0 && core_hold == 0, "R11 reset outputs", wcount_o, 0);

        wr(3'd5, 16'd0);
        @(negedge clk);
        chk(busy_o == 0, "R1 zero count no start", busy_o, 0);

        // page carry mid-word, 24-bit load
        run_xfer(0, 2'b00, 0, 1, 8, 14'h3FFE, 5, 3, 0, "pm24 load page carry");
        run_xfer(1, 2'b00, 0, 2, 40, 14'h3FFF, 9, 2, 0, "pm24 store page carry");
        run_xfer(0, 2'b01, 0, 0, 60, 14'h0100, 1, 4, 0, "dm16 load");
        run_xfer(1, 2'b01, 0, 1, 70, 14'h0200, 1, 3, 0, "dm16 store");
        run_xfer(0, 2'b10, 0, 0, 80, 14'h0300, 2, 3, 0, "dm8 hi load");
        run_xfer(0, 2'b11, 0, 3, 90, 14'h0400, 2, 3, 0, "dm8 lo load");
        run_xfer(1, 2'b10, 0, 0, 100, 14'h0500, 2, 2, 0, "dm8 hi store");
        run_xfer(1, 2'b11, 0, 0, 110, 14'h0600, 2, 2, 0, "dm8 lo store");
        run_xfer(0, 2'b01, 1, 1, 120, 14'h0700, 3, 2, 0, "halt mode");
        run_xfer(0, 2'b01, 0, 4, 130, 14'h0800, 3, 3, 1, "R12 writes while busy");

        rnd_core = 1;
        for (int r = 0; r < 12; r++) begin
            run_xfer(1'($urandom), 2'($urandom), 1'($urandom), int'($urandom % 4),
                     int'($urandom % 200), int'($urandom % 16384), int'($urandom % 256),
                     1 + int'($urandom % 6), 0, "random");
        end
        rnd_core = 0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule